// File: doc/BRIEF.md
# Two-Bit Branch Direction Table

This block guesses whether a conditional branch will be taken. It holds a direct-mapped array of two-bit saturating counters, one per slot, selected by a slice of the program counter just above the instruction-alignment bits. There are no tags, so branches whose PCs share that slice share a counter.

The fetch side presents a PC on the lookup port and gets a taken or not-taken guess back in the same cycle, read combinationally from the selected counter. The resolve side presents a completed branch's PC, its real direction and a valid strobe. The selected counter then steps one state toward the observed direction. Because the counter has hysteresis, a single surprise in a strongly biased branch does not flip its guess.

After a synchronous reset, an internal sequencer walks every slot and writes the weakly not-taken value into it, one slot per cycle. This lets the storage stay an ordinary single-write-port RAM. For the length of that walk, every lookup answers not-taken and every training write is dropped.

Top module: `branch_hist_table`

## Requirements
- R1: `pred_taken` is the most significant bit of the counter selected by `pred_pc`, with counter encoding 00 = strongly not-taken, 01 = weakly not-taken, 10 = weakly taken, 11 = strongly taken. It follows a change of `pred_pc` within the same cycle, with no clock edge in between.
- R2: The slot index is `pc[ALIGN_W+IDX_W-1:ALIGN_W]`. PC bits below and above that slice have no effect on which counter is read or trained.
- R3: While reset is held, and after it, every counter holds weakly not-taken (01). Lookups answer not-taken, and a single taken training of a slot makes that slot predict taken.
- R4: A valid taken training moves the counter one step toward 11 and leaves 11 unchanged.
- R5: A valid not-taken training moves the counter one step toward 00 and leaves 00 unchanged.
- R6: From a strongly biased state, two consecutive opposite outcomes are needed before the prediction changes.
- R7: In a cycle with `upd_valid` low, no counter changes, whatever `upd_pc` and `upd_taken` carry.
- R8: When a lookup and a training hit the same slot in one cycle, the lookup returns the value from before the training. The new value is visible from the next cycle.
- R9: For the 2^IDX_W cycles after reset is released, lookups answer not-taken and training requests are discarded.
- R10: Training changes only the addressed slot. Other slots keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Direction guess for `pred_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch (1 = taken) |

## Verification
On every cycle, the bound checker enforces these properties:
- Lookups stay silent and training stays blocked while the clear walk runs.
- No write occurs without a valid strobe.
- A same-slot lookup returns the pre-training value.
- The slot just trained, when looked up in the following cycle, points the way the counter step demands.
- An idle cycle leaves an unchanged lookup unchanged.

Saturation at both ends, the two-miss hysteresis, PC-bit aliasing and the reset value of untouched slots depend on histories several trainings long. Only the bench's sequences on chosen slots can show them.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_INIT = CTR_WNT;

  // One saturating step toward the observed direction.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_INIT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int ALIGN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // Alignment bits are always zero for fetched instructions; skip them.
  assign idx = pc[ALIGN_W +: IDX_W];
endmodule

// File: rtl/bht_clear_seq.sv
module bht_clear_seq #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (&ptr) busy <= 1'b0;
    end
  end

  assign wr_en  = busy & ~rst;
  assign wr_idx = ptr;
endmodule

// File: rtl/bht_ctr_ram.sv
module bht_ctr_ram #(
  parameter int IDX_W = 12
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  bht_pkg::ctr_e      wdata,
  input  logic [IDX_W-1:0]   ra_idx,
  output bht_pkg::ctr_e      ra_data,
  input  logic [IDX_W-1:0]   rb_idx,
  output bht_pkg::ctr_e      rb_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  // Asynchronous reads: both return the pre-write contents in a write cycle.
  assign ra_data = bht_pkg::ctr_e'(mem[ra_idx]);
  assign rb_data = bht_pkg::ctr_e'(mem[rb_idx]);
endmodule

// File: rtl/bht_train.sv
module bht_train #(
  parameter int IDX_W = 12
) (
  input  logic               upd_valid,
  input  logic               upd_taken,
  input  logic               block,
  input  logic [IDX_W-1:0]   upd_idx,
  input  bht_pkg::ctr_e      cur,
  output logic               we,
  output logic [IDX_W-1:0]   widx,
  output bht_pkg::ctr_e      wdata
);
  assign we    = upd_valid & ~block;
  assign widx  = upd_idx;
  assign wdata = bht_pkg::ctr_step(cur, upd_taken);
endmodule

// File: rtl/branch_hist_table.sv
module branch_hist_table #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  import bht_pkg::*;

  logic [IDX_W-1:0] pred_idx;
  logic [IDX_W-1:0] upd_idx;
  logic             clr_busy;
  logic             clr_we;
  logic [IDX_W-1:0] clr_idx;
  logic             trn_we;
  logic [IDX_W-1:0] trn_idx;
  ctr_e             trn_wdata;
  ctr_e             trn_cur;
  ctr_e             pred_ctr;
  logic             ram_we;
  logic [IDX_W-1:0] ram_widx;
  ctr_e             ram_wdata;

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_pidx (
    .pc(pred_pc), .idx(pred_idx)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_uidx (
    .pc(upd_pc), .idx(upd_idx)
  );

  bht_clear_seq #(.IDX_W(IDX_W)) u_clr (
    .clk(clk), .rst(rst), .busy(clr_busy), .wr_en(clr_we), .wr_idx(clr_idx)
  );

  bht_train #(.IDX_W(IDX_W)) u_trn (
    .upd_valid(upd_valid), .upd_taken(upd_taken), .block(clr_busy | rst),
    .upd_idx(upd_idx), .cur(trn_cur),
    .we(trn_we), .widx(trn_idx), .wdata(trn_wdata)
  );

  // Single write port: the clear walk owns it until done.
  always_comb begin
    if (clr_we) begin
      ram_we    = 1'b1;
      ram_widx  = clr_idx;
      ram_wdata = CTR_INIT;
    end else begin
      ram_we    = trn_we;
      ram_widx  = trn_idx;
      ram_wdata = trn_wdata;
    end
  end

  bht_ctr_ram #(.IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .widx(ram_widx), .wdata(ram_wdata),
    .ra_idx(pred_idx), .ra_data(pred_ctr),
    .rb_idx(upd_idx),  .rb_data(trn_cur)
  );

  // Unswept slots are masked to the reset value, which predicts not-taken.
  assign pred_taken = ~clr_busy & ctr_dir(pred_ctr);
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int ALIGN_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic            clr_busy,
  input logic            trn_we,
  input logic [1:0]      trn_cur
);
  logic [IDX_W-1:0] p_idx;
  logic [IDX_W-1:0] u_idx;
  assign p_idx = pred_pc[ALIGN_W +: IDX_W];
  assign u_idx = upd_pc[ALIGN_W +: IDX_W];

  // R3
  reset_starts_clear_chk: assert property (@(posedge clk)
    rst |=> clr_busy);

  // R9
  clear_silent_chk: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !pred_taken);

  // R9
  clear_blocks_train_chk: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !trn_we);

  // R7
  no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |-> !trn_we);

  // R8
  same_slot_old_value_chk: assert property (@(posedge clk) disable iff (rst)
    (trn_we && p_idx == u_idx) |-> (pred_taken == trn_cur[1]));

  // R4
  taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (trn_we && upd_taken && trn_cur != 2'b00)
      |=> ((p_idx != $past(u_idx)) || pred_taken));

  // R5
  not_taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (trn_we && !upd_taken && trn_cur != 2'b11)
      |=> ((p_idx != $past(u_idx)) || !pred_taken));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trn_we && !clr_busy) |=> (!$stable(pred_pc) || $stable(pred_taken)));
endmodule

bind branch_hist_table bht_checker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)
) u_chk (
  .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
  .clr_busy(clr_busy), .trn_we(trn_we), .trn_cur(trn_cur)
);

// File: tb/branch_hist_table_tb.sv
`timescale 1ns/1ps
module branch_hist_table_tb;
  localparam int PC_W    = 16;
  localparam int IDX_W   = 6;
  localparam int ALIGN_W = 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NVEC    = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  branch_hist_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_dut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // Vector: {upd_valid, upd slot, upd_taken, lookup slot, expected guess, req}
  localparam logic [18:0] VECS [NVEC] = '{
    {1'b1, 6'd5,  1'b1, 6'd5,  1'b0, 4'd3},   // R3 fresh slot is weak NT
    {1'b0, 6'd0,  1'b0, 6'd5,  1'b1, 4'd4},   // R4 WNT->WT
    {1'b1, 6'd5,  1'b1, 6'd5,  1'b1, 4'd4},   // R4 ->ST
    {1'b1, 6'd5,  1'b1, 6'd5,  1'b1, 4'd4},   // R4 stays ST
    {1'b1, 6'd5,  1'b0, 6'd5,  1'b1, 4'd6},   // R6 first miss
    {1'b1, 6'd5,  1'b0, 6'd5,  1'b1, 4'd6},   // R6 second miss
    {1'b0, 6'd0,  1'b0, 6'd5,  1'b0, 4'd6},   // R6 flipped after two
    {1'b1, 6'd5,  1'b0, 6'd5,  1'b0, 4'd5},   // R5 ->SNT
    {1'b1, 6'd5,  1'b0, 6'd5,  1'b0, 4'd5},   // R5 stays SNT
    {1'b1, 6'd5,  1'b1, 6'd5,  1'b0, 4'd5},   // R5 ->WNT
    {1'b1, 6'd5,  1'b1, 6'd5,  1'b0, 4'd5},   // R5 ->WT
    {1'b0, 6'd0,  1'b0, 6'd5,  1'b1, 4'd5},   // R5 floor held
    {1'b1, 6'd9,  1'b1, 6'd5,  1'b1, 4'd10},  // R10 train another slot
    {1'b0, 6'd0,  1'b0, 6'd9,  1'b1, 4'd10},  // R10
    {1'b0, 6'd0,  1'b0, 6'd10, 1'b0, 4'd10},  // R10 neighbour untouched
    {1'b0, 6'd0,  1'b0, 6'd8,  1'b0, 4'd10},  // R10 neighbour untouched
    {1'b1, 6'd5,  1'b0, 6'd5,  1'b1, 4'd8},   // R8 same-slot old value
    {1'b0, 6'd0,  1'b0, 6'd5,  1'b0, 4'd8},   // R8 new value next cycle
    {1'b0, 6'd10, 1'b1, 6'd10, 1'b0, 4'd7},   // R7 strobe low
    {1'b0, 6'd0,  1'b0, 6'd10, 1'b0, 4'd7}    // R7 slot unchanged
  };

  function automatic logic [PC_W-1:0] pc_of(input int slot);
    return PC_W'(slot) << ALIGN_W;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pred_taken=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input int us, input logic t, input int ps);
    upd_valid = v;
    upd_pc    = pc_of(us);
    upd_taken = t;
    pred_pc   = pc_of(ps);
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: run=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    // Reset held: lookup answers not-taken (R3)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pred_taken, 1'b0, "R3 during reset");
    rst = 1'b0;

    // Clear walk: training dropped, lookups silent (R9)
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 3, 1'b1, 3);
      #1 check(pred_taken, 1'b0, "R9 lookup during clear");
      step();
    end
    drive(1'b0, 0, 1'b0, 3);
    repeat (ENTRIES) step();
    check(pred_taken, 1'b0, "R9 training during clear dropped");
    drive(1'b1, 3, 1'b1, 3);
    step();
    drive(1'b0, 0, 1'b0, 3);
    #1 check(pred_taken, 1'b1, "R3 one taken flips weak NT");

    // Table of vectors
    for (int n = 0; n < NVEC; n++) begin
      drive(VECS[n][18], int'(VECS[n][17:12]), VECS[n][11],
            int'(VECS[n][10:5]));
      #1 check(pred_taken, VECS[n][4], $sformatf("R%0d vector %0d", VECS[n][3:0], n));
      step();
    end
    drive(1'b0, 0, 1'b0, 0);

    // R1: lookup follows pred_pc with no clock edge (slot 9 = WT, 10 = WNT)
    pred_pc = pc_of(9);
    #1 check(pred_taken, 1'b1, "R1 combinational slot 9");
    pred_pc = pc_of(10);
    #1 check(pred_taken, 1'b0, "R1 combinational slot 10");
    pred_pc = pc_of(9);
    #1 check(pred_taken, 1'b1, "R1 combinational back to 9");
    step();

    // R2: low and high PC bits ignored (slot 5 = WNT)
    upd_valid = 1'b1;
    upd_taken = 1'b1;
    upd_pc    = pc_of(5) | PC_W'(3) | (PC_W'(1) << (ALIGN_W + IDX_W));
    pred_pc   = pc_of(6);
    step();
    upd_valid = 1'b0;
    pred_pc   = pc_of(5);
    #1 check(pred_taken, 1'b1, "R2 aliased PC trains slot 5");
    pred_pc = pc_of(5) | PC_W'(2) | (PC_W'(3) << (ALIGN_W + IDX_W + 1));
    #1 check(pred_taken, 1'b1, "R2 aliased lookup of slot 5");
    pred_pc = pc_of(6);
    #1 check(pred_taken, 1'b0, "R2 slot 6 untouched");
    step();

    // R3: reset in mid-run returns slots to weak not-taken
    rst = 1'b1;
    pred_pc = pc_of(9);
    step();
    check(pred_taken, 1'b0, "R3 reset masks trained slot");
    rst = 1'b0;
    repeat (ENTRIES + 2) step();
    check(pred_taken, 1'b0, "R3 slot 9 cleared");
    drive(1'b1, 9, 1'b1, 9);
    step();
    drive(1'b0, 0, 1'b0, 9);
    #1 check(pred_taken, 1'b1, "R3 cleared slot is weak");

    done = 1'b1;
    finish_run();
  end
endmodule